// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

The block is a 24-bit timer that counts down and reloads itself, for use as a fixed-rate system tick. Software programs a reload value N. The counter then steps from N down to zero and loads N again, so one count-reached-zero event occurs every N+1 ticks. A tick is either every processor clock cycle or each single-cycle pulse on a reference tick input. A control bit selects between the two.

Each event sets a sticky flag in the control/status register. Reading that register clears the flag. If the interrupt-enable bit is set, the event also drives a one-cycle pulse on the interrupt line. Any write to the current-value register zeroes the counter and the flag. A read-only calibration register reports a build-time 10 ms reload value, whether that value is exact, and whether a reference clock exists. When the reference clock is absent, the clock-source bit is fixed at 1.

The register bus is a plain 32-bit word interface with single-cycle access. Word index 0 is control/status, 1 is reload, 2 is current value and 3 is calibration. Read data is combinational and is zero whenever no read is in progress.

Top module: `sys_tick_timer`

## Requirements
- R1: Control/status word (index 0) fields are: bit 0 counting enable, bit 1 interrupt enable, bit 2 clock source (1 = processor clock). They are written by a write to index 0, read back unchanged, and all three reset to 0.
- R2: While enabled, the counter decrements by one on each tick. With counting disabled, or without a tick, it holds its value.
- R3: A tick that finds the counter at zero loads the reload value, so reload value N gives one event every N+1 ticks.
- R4: The reload word (index 1) stores write bits [23:0]. Bits [31:24] read as zero.
- R5: Any write to the current-value word (index 2) clears the counter and the flag to zero, whatever data is written. Bits [31:24] of index 2 read as zero.
- R6: The flag (bit 16 of index 0) is set on the tick that moves the counter from 1 to 0. It is cleared by a read of index 0. A set in the same cycle as the read wins.
- R7: The interrupt output is high for exactly one cycle: the first cycle in which the counter shows zero after a 1-to-0 step. It pulses only when bit 1 of index 0 was set at that step.
- R8: With bit 2 clear, the counter advances only on cycles where the reference tick input is high.
- R9: The calibration word (index 3) reads {no-reference bit 31, inexact bit 30, zeros in bits 29:24, 10 ms value in bits 23:0}, all from parameters.
- R10: When the no-reference parameter is 1, bit 2 of index 0 reads as 1 and a write of 0 does not clear it.
- R11: With a reload value of zero, the counter stops at zero after its next wrap, and no further events occur.
- R12: When not reading (reg_en low or reg_we high), reg_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| ref_tick | input | 1 | Reference clock enable pulse |
| irq | output | 1 | Count-reached-zero interrupt pulse |

## Verification
A wrong counter value shows at the current-value read on the very next bus read. It also shifts the flag and interrupt timing by the same error, one period later at the latest. A flag that is set or cleared on the wrong cycle shows on the next status read. A reload or source-select fault moves the interval between interrupt pulses away from N+1 ticks within a single period. The random traffic reads the counter and status continually, so most divergence appears within a few cycles.

// File: rtl/sys_tick_pkg.sv
// Shared constants and types for the reload down-counter timer.
// Assumes a 4-word register window addressed by a 2-bit word index.
package sys_tick_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_CURR   = 2'd2;
    localparam logic [1:0] ADDR_CALIB  = 2'd3;

    localparam int BIT_EN    = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_FLAG  = 16;

    typedef struct packed {
        logic proc_src;
        logic irq_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/stt_tick_gen.sv
// Tick qualifier: produces one count enable per cycle in which the timer
// should advance. Assumes ref_tick is already synchronous, one cycle per pulse.
module stt_tick_gen (
    input  logic run,
    input  logic proc_src,
    input  logic ref_tick,
    output logic tick
);
    // Advance on every cycle with the processor source, else on reference pulses.
    always_comb begin
        tick = run && (proc_src || ref_tick);
    end
endmodule

// File: rtl/stt_down_counter.sv
// Down counter with reload at zero and a synchronous clear.
// Assumes clear has priority over tick. hit_zero flags the 1-to-0 step.
module stt_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] count_q;

    // Counter state: clear, reload at zero, or decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= ZERO;
        end else if (clear) begin
            count_q <= ZERO;
        end else if (tick) begin
            if (count_q == ZERO) count_q <= reload_val;
            else                 count_q <= count_q - ONE;
        end
    end

    // Event strobe for the step from 1 to 0.
    always_comb begin
        hit_zero = tick && !clear && (count_q == ONE);
        count    = count_q;
    end

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !clear && count_q != ZERO |=> count_q == $past(count_q) - ONE); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !clear |=> $stable(count_q)); // R2
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !clear && count_q == ZERO |=> count_q == $past(reload_val)); // R3
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count_q == ZERO); // R5
    AST_ZERO_RELOAD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        count_q == ZERO && reload_val == ZERO |=> count_q == ZERO); // R11
endmodule

// File: rtl/stt_ctrl_regs.sv
// Register file: control bits, reload value, sticky flag, interrupt pulse
// and the read multiplexer. Assumes single-cycle bus accesses. The status
// read clears the flag at the same edge that completes the read.
module stt_ctrl_regs
    import sys_tick_pkg::*;
#(
    parameter int             CNT_W        = 24,
    parameter logic [CNT_W-1:0] CAL_TENMS  = '0,
    parameter bit             CAL_INEXACT  = 1'b0,
    parameter bit             NO_REF       = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [CNT_W-1:0] count,
    input  logic             hit_zero,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload_val,
    output logic             count_clear,
    output logic             irq
);
    localparam int PAD_W = 32 - CNT_W;

    ctrl_t            ctrl_q;
    logic             src_q;
    logic [CNT_W-1:0] reload_q;
    logic             flag_q;
    logic             irq_q;
    logic             wr_ctrl, wr_reload, rd_ctrl, rd_any;
    logic             src_eff;
    logic             unused_wdata_hi;

    // Access decode.
    always_comb begin
        wr_ctrl     = reg_en &&  reg_we && reg_addr == ADDR_CTRL;
        wr_reload   = reg_en &&  reg_we && reg_addr == ADDR_RELOAD;
        count_clear = reg_en &&  reg_we && reg_addr == ADDR_CURR;
        rd_any      = reg_en && !reg_we;
        rd_ctrl     = rd_any && reg_addr == ADDR_CTRL;
    end

    assign unused_wdata_hi = ^reg_wdata[31:CNT_W];

    // Clock-source bit: stored, or tied to 1 when no reference exists.
    generate
        if (NO_REF) begin : g_src_forced
            assign src_eff = 1'b1;
        end else begin : g_src_stored
            assign src_eff = src_q;
        end
    endgenerate

    // Control and reload storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.run    <= 1'b0;
            ctrl_q.irq_en <= 1'b0;
            src_q         <= 1'b0;
            reload_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run    <= reg_wdata[BIT_EN];
                ctrl_q.irq_en <= reg_wdata[BIT_IE];
                src_q         <= reg_wdata[BIT_SRC];
            end
            if (wr_reload) reload_q <= reg_wdata[CNT_W-1:0];
        end
    end

    assign ctrl_q.proc_src = src_eff;

    // Sticky flag: set wins over the clear from a status read or counter write.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (hit_zero)                 flag_q <= 1'b1;
        else if (rd_ctrl || count_clear)   flag_q <= 1'b0;
    end

    // Interrupt pulse, one cycle, aligned with the counter showing zero.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= hit_zero && ctrl_q.irq_en;
    end

    // Read multiplexer; zero when no read is in progress.
    always_comb begin
        reg_rdata = '0;
        if (rd_any) begin
            unique case (reg_addr)
                ADDR_CTRL: begin
                    reg_rdata[BIT_EN]   = ctrl_q.run;
                    reg_rdata[BIT_IE]   = ctrl_q.irq_en;
                    reg_rdata[BIT_SRC]  = src_eff;
                    reg_rdata[BIT_FLAG] = flag_q;
                end
                ADDR_RELOAD: reg_rdata = {{PAD_W{1'b0}}, reload_q};
                ADDR_CURR:   reg_rdata = {{PAD_W{1'b0}}, count};
                default:     reg_rdata = {NO_REF, CAL_INEXACT, {(PAD_W-2){1'b0}}, CAL_TENMS};
            endcase
        end
    end

    assign ctrl       = ctrl_q;
    assign reload_val = reload_q;
    assign irq        = irq_q;

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl_q.irq_en)); // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q); // R6
    AST_FLAG_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl && !hit_zero |=> !flag_q); // R6
    AST_SRC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        NO_REF |-> src_eff); // R10
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |-> reg_rdata == '0); // R12
endmodule

// File: rtl/sys_tick_timer.sv
// Top of the reload down-counter timer: register file, tick qualifier and
// counter. Assumes ref_tick is synchronous to clk and at most one cycle wide.
module sys_tick_timer
    import sys_tick_pkg::*;
#(
    parameter int               CNT_W       = 24,
    parameter logic [CNT_W-1:0] CAL_TENMS   = '0,
    parameter bit               CAL_INEXACT = 1'b0,
    parameter bit               NO_REF      = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ref_tick,
    output logic        irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             count_clear;
    logic             hit_zero;
    logic             tick;

    stt_ctrl_regs #(
        .CNT_W(CNT_W), .CAL_TENMS(CAL_TENMS),
        .CAL_INEXACT(CAL_INEXACT), .NO_REF(NO_REF)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .count(count), .hit_zero(hit_zero),
        .ctrl(ctrl), .reload_val(reload_val),
        .count_clear(count_clear), .irq(irq)
    );

    stt_tick_gen i_tick (
        .run(ctrl.run), .proc_src(ctrl.proc_src),
        .ref_tick(ref_tick), .tick(tick)
    );

    stt_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(count_clear),
        .reload_val(reload_val), .count(count), .hit_zero(hit_zero)
    );
endmodule

// File: tb/test_sys_tick_timer.sv
`timescale 1ns/1ps
module test_sys_tick_timer;
    localparam logic [23:0] TENMS = 24'd2_500_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0, ref_tick = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    logic        n_en = 1'b0, n_we = 1'b0;
    logic [1:0]  n_addr = 2'd0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;
    logic        n_irq;

    int checks = 0, fails = 0, irq_seen = 0, cyc = 0;
    bit done = 0;

    // Bench model state
    bit m_en, m_ie, m_src, m_flag, m_irq;
    logic [23:0] m_rel, m_cur;

    always #2 clk = ~clk;

    sys_tick_timer #(.CAL_TENMS(TENMS), .CAL_INEXACT(1'b1), .NO_REF(1'b0)) i_sys_tick_timer (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ref_tick(ref_tick), .irq(irq));

    sys_tick_timer #(.CAL_TENMS(24'd0), .CAL_INEXACT(1'b0), .NO_REF(1'b1)) i_noref (
        .clk(clk), .rst_n(rst_n), .reg_en(n_en), .reg_we(n_we),
        .reg_addr(n_addr), .reg_wdata(n_wdata), .reg_rdata(n_rdata),
        .ref_tick(1'b0), .irq(n_irq));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input bit en, input bit we, input logic [1:0] a);
        if (!en || we) return 32'h0;
        case (a)
            2'd0:    return {15'h0, m_flag, 13'h0, m_src, m_ie, m_en};
            2'd1:    return {8'h0, m_rel};
            2'd2:    return {8'h0, m_cur};
            default: return {1'b0, 1'b1, 6'h0, TENMS};
        endcase
    endfunction

    function automatic string tag_of(input bit en, input bit we, input logic [1:0] a);
        if (!en || we) return "R12";
        case (a)
            2'd0:    return "R1 R6 R8";
            2'd1:    return "R4";
            2'd2:    return "R2 R3 R5 R11";
            default: return "R9";
        endcase
    endfunction

    // One bus cycle: drive at negedge, check outputs, advance the model.
    task automatic step(input bit en, input bit we, input logic [1:0] a,
                        input logic [31:0] wd, input bit rt);
        logic [31:0] e;
        bit rd_ctrl, wr_cur, tick, hit;
        @(negedge clk);
        reg_en = en; reg_we = we; reg_addr = a; reg_wdata = wd; ref_tick = rt;
        cyc++;
        #1;
        e = exp_read(en, we, a);
        check(reg_rdata == e, tag_of(en, we, a), reg_rdata, e);
        check(irq == m_irq, "R7 irq", {31'h0, irq}, {31'h0, m_irq});
        if (irq) irq_seen++;
        rd_ctrl = en && !we && a == 2'd0;
        wr_cur  = en && we && a == 2'd2;
        tick    = m_en && (m_src || rt);
        hit     = tick && !wr_cur && m_cur == 24'd1;
        m_irq   = hit && m_ie;
        if (hit) m_flag = 1'b1;
        else if (rd_ctrl || wr_cur) m_flag = 1'b0;
        if (wr_cur) m_cur = '0;
        else if (tick) m_cur = (m_cur == 0) ? m_rel : m_cur - 24'd1;
        if (en && we && a == 2'd0) begin
            m_en = wd[0]; m_ie = wd[1]; m_src = wd[2];
        end
        if (en && we && a == 2'd1) m_rel = wd[23:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int first, second, r, cnt0;
        logic [31:0] wd;
        void'($urandom(32'h5EED_0042));
        m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0; m_rel = 0; m_cur = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state of every readable word (R1, R4, R5, R9)
        for (int a = 0; a < 4; a++) step(1'b1, 1'b0, 2'(a), 32'h0, 1'b0);

        // Reload upper bits ignored (R4), current write data ignored (R5)
        step(1'b1, 1'b1, 2'd1, 32'hFF00_0004, 1'b0);
        step(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        step(1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
        step(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);

        // Period with reload 4 on the processor clock (R3, R7)
        step(1'b1, 1'b1, 2'd0, 32'h7, 1'b0);
        first = -1; second = -1;
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
            if (irq && first < 0) first = cyc;
            else if (irq && second < 0) second = cyc;
        end
        check(second - first == 5, "R3 period", 32'(second - first), 32'd5);
        step(1'b1, 1'b0, 2'd0, 32'h0, 1'b0);   // flag read and clear (R6)
        step(1'b1, 1'b0, 2'd0, 32'h0, 1'b0);

        // Reference source with no pulses: counter holds (R8)
        step(1'b1, 1'b1, 2'd0, 32'h3, 1'b0);
        step(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);
        wd = reg_rdata;
        idle(10);
        step(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);
        check(reg_rdata == wd, "R8 hold without ref_tick", reg_rdata, wd);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 2'd0, 32'h0, 1'(i % 2));

        // Reload zero: one final wrap at most, then silence (R11)
        step(1'b1, 1'b1, 2'd0, 32'h7, 1'b0);
        step(1'b1, 1'b1, 2'd1, 32'h0, 1'b0);
        idle(10);
        cnt0 = irq_seen;
        idle(20);
        check(irq_seen == cnt0, "R11 no events after stop", 32'(irq_seen - cnt0), 32'd0);
        step(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);

        // No-reference instance: source bit stuck at 1 (R10)
        @(negedge clk); n_en = 1; n_we = 1; n_addr = 2'd0; n_wdata = 32'h1;
        @(negedge clk); n_we = 0; #1;
        check(n_rdata[2:0] == 3'b101, "R10 source forced", {29'h0, n_rdata[2:0]}, 32'h5);
        n_addr = 2'd3; #1;
        check(n_rdata == 32'h8000_0000, "R9 R10 calib no-ref", n_rdata, 32'h8000_0000);
        n_en = 0;

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom % 100);
            if (r < 6)       step(1'b1, 1'b1, 2'd0, $urandom, 1'($urandom % 3 == 0));
            else if (r < 10) step(1'b1, 1'b1, 2'd1,
                                  (r == 9) ? $urandom : ($urandom % 7), 1'($urandom % 3 == 0));
            else if (r < 12) step(1'b1, 1'b1, 2'd2, $urandom, 1'($urandom % 3 == 0));
            else if (r < 35) step(1'b1, 1'b0, 2'd0, 32'h0, 1'($urandom % 3 == 0));
            else if (r < 70) step(1'b1, 1'b0, 2'($urandom), 32'h0, 1'($urandom % 3 == 0));
            else             step(1'b0, 1'($urandom), 2'($urandom), $urandom, 1'($urandom % 3 == 0));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule